// File: doc/BRIEF.md
# Four-Way Dot-Product Unit

This block is a two-stage pipelined multiply-and-sum datapath for packed media arithmetic. Each cycle it can accept two 64-bit operands, an operation code, a signedness control and a valid strobe. Its main operation takes the four 16-bit lanes of each operand and forms the sum of the four lane products. That sum is kept at full precision, rounded once, and the upper half of the 32-bit product range is returned, so the result has the same width as one input lane. Rounding once avoids the error that appears when two separately rounded pair sums are added.

The same pipeline also computes a two-product sum on the two 32-bit lanes of the operands. Optionally, a 64-bit accumulator operand is added to or subtracted from that sum. In the first stage the unit forms all products, along with two partial sums held in carry-save form. The second stage merges the two partial sums with a further carry-save step, resolves them with one carry-propagate adder, and registers the result. A new operation may enter every cycle, and each result leaves exactly two cycles after its operands were accepted.

The pipeline has no control states. Each stage is a single valid-qualified register set: a stage loads when its valid input is high and holds otherwise.

Top module: `dp4_unit`

## Requirements
- R1: With `in_op` = 0 (four-product mode), lane i of each operand is bits [16i+15:16i] for i = 0..3. `out_res[15:0]` equals bits [31:16] of the exact integer (A0·B0 + A1·B1 + A2·B2 + A3·B3 + 32768), and `out_res[63:16]` is zero.
- R2: `in_signed` = 1 treats every lane and the accumulator as two's complement. `in_signed` = 0 treats them as unsigned.
- R3: With `in_op` = 1 (pair mode), word lane j is bits [32j+31:32j] for j = 0..1, and `out_res` equals the low 64 bits of A0·B0 + A1·B1.
- R4: With `in_op` = 2, `out_res` equals the low 64 bits of A0·B0 + A1·B1 + `in_acc`.
- R5: With `in_op` = 3, `out_res` equals the low 64 bits of A0·B0 + A1·B1 − `in_acc`.
- R6: `in_acc` has no effect on the result when `in_op` is 0 or 1.
- R7: `out_valid` is high exactly two clock edges after each edge that samples `in_valid` high, and otherwise low. Operations issued on consecutive cycles return on consecutive cycles.
- R8: While `out_valid` is low, `out_res` keeps the last result, whatever values the inputs carry while `in_valid` is low.
- R9: While `rst_n` is low, `out_valid` and `out_res` are zero.
- R10: In four-product mode the rounding is applied once to the full sum. Two pair sums that would each round up on their own therefore contribute only the single rounding of their exact total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and op code are presented this cycle |
| in_op | input | 2 | 0 four-product, 1 pair sum, 2 pair sum plus accumulator, 3 pair sum minus accumulator |
| in_signed | input | 1 | 1 signed lanes, 0 unsigned lanes |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| in_acc | input | 64 | Accumulator operand for op codes 2 and 3 |
| out_valid | output | 1 | Result is valid this cycle |
| out_res | output | 64 | Result |

## Verification
Every result is due two rising edges after the edge that accepted its operands. When the driver issues an operation, it records the cycle number at which the result must appear, together with the expected value. The monitor samples at the falling edge and checks both the value and that cycle number. It also flags a result that is missing at its due cycle, or one that changed while `out_valid` was low.

// File: rtl/dp4_pkg.sv
package dp4_pkg;

    typedef enum logic [1:0] {
        OP_DOT4     = 2'd0,
        OP_PAIR     = 2'd1,
        OP_PAIR_ADD = 2'd2,
        OP_PAIR_SUB = 2'd3
    } dp_op_e;

endpackage

// File: rtl/dp4_mul.sv
// One lane multiplier: operands extended by one bit (sign or zero) and
// multiplied as signed, product sign-extended to the internal width.
module dp4_mul #(
    parameter int AW = 16,
    parameter int PW = 68
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic          sgn,
    output logic [PW-1:0] p
);
    localparam int FW = 2 * AW + 2;

    logic signed [AW:0]   ax;
    logic signed [AW:0]   bx;
    logic signed [FW-1:0] full;

    always_comb begin
        ax   = {sgn & a[AW-1], a};
        bx   = {sgn & b[AW-1], b};
        full = FW'(ax) * FW'(bx);
        p    = {{(PW - FW){full[FW-1]}}, full};
    end
endmodule

// File: rtl/dp4_csa.sv
// Three-input carry-save compressor.
module dp4_csa #(
    parameter int W = 68
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] maj;

    always_comb begin
        s   = x ^ y ^ z;
        maj = (x & y) | (x & z) | (y & z);
        c   = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/dp4_stage1.sv
// Stage one: lane products, operand selection and two carry-save pair sums.
module dp4_stage1
    import dp4_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int DATA_W = 64,
    parameter int IW     = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_signed,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_acc,
    output logic              st_valid,
    output logic [IW-1:0]     st_s_lo,
    output logic [IW-1:0]     st_c_lo,
    output logic [IW-1:0]     st_s_hi,
    output logic [IW-1:0]     st_c_hi,
    output logic              st_dot,
    output logic              st_cin
);
    localparam int WORD_W = DATA_W / 2;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int WORDS  = DATA_W / WORD_W;
    localparam int RND_AT = LANE_W - 1;

    logic [IW-1:0] half_p [LANES];
    logic [IW-1:0] word_p [WORDS];

    for (genvar g = 0; g < LANES; g++) begin : g_half
        dp4_mul #(.AW(LANE_W), .PW(IW)) u_mul (
            .a   (in_a[g*LANE_W +: LANE_W]),
            .b   (in_b[g*LANE_W +: LANE_W]),
            .sgn (in_signed),
            .p   (half_p[g])
        );
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        dp4_mul #(.AW(WORD_W), .PW(IW)) u_mul (
            .a   (in_a[g*WORD_W +: WORD_W]),
            .b   (in_b[g*WORD_W +: WORD_W]),
            .sgn (in_signed),
            .p   (word_p[g])
        );
    end

    dp_op_e        op_e;
    logic          is_dot;
    logic [IW-1:0] acc_x;
    logic [IW-1:0] pr0, pr1, pr2, pr3;
    logic [IW-1:0] add_lo, add_hi;
    logic          cin;
    logic [IW-1:0] ps_lo, pc_lo, ps_hi, pc_hi;

    always_comb begin
        op_e   = dp_op_e'(in_op);
        is_dot = (op_e == OP_DOT4);
        acc_x  = {{(IW - DATA_W){in_signed & in_acc[DATA_W-1]}}, in_acc};
        pr0    = is_dot ? half_p[0] : word_p[0];
        pr1    = is_dot ? half_p[1] : word_p[1];
        pr2    = is_dot ? half_p[2] : '0;
        pr3    = is_dot ? half_p[3] : '0;
        add_hi = is_dot ? (IW'(1) << RND_AT) : '0;
        add_lo = '0;
        cin    = 1'b0;
        unique case (op_e)
            OP_PAIR_ADD: add_lo = acc_x;
            OP_PAIR_SUB: begin
                add_lo = ~acc_x;
                cin    = 1'b1;
            end
            default: add_lo = '0;
        endcase
    end

    dp4_csa #(.W(IW)) u_csa_lo (.x(pr0), .y(pr1), .z(add_lo), .s(ps_lo), .c(pc_lo));
    dp4_csa #(.W(IW)) u_csa_hi (.x(pr2), .y(pr3), .z(add_hi), .s(ps_hi), .c(pc_hi));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_s_lo  <= '0;
            st_c_lo  <= '0;
            st_s_hi  <= '0;
            st_c_hi  <= '0;
            st_dot   <= 1'b0;
            st_cin   <= 1'b0;
        end else begin
            st_valid <= in_valid;
            if (in_valid) begin
                st_s_lo <= ps_lo;
                st_c_lo <= pc_lo;
                st_s_hi <= ps_hi;
                st_c_hi <= pc_hi;
                st_dot  <= is_dot;
                st_cin  <= cin;
            end
        end
    end

    // R3 / R1: the low pair compressor keeps the exact sum of its inputs
    p_pair_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (IW'(ps_lo + pc_lo) == IW'(pr0 + pr1 + add_lo)));

    // R10: the high pair compressor keeps products plus the single rounding term
    p_pair_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (IW'(ps_hi + pc_hi) == IW'(pr2 + pr3 + add_hi)));
endmodule

// File: rtl/dp4_stage2.sv
// Stage two: four-to-two merge, carry-propagate add and result selection.
module dp4_stage2 #(
    parameter int LANE_W = 16,
    parameter int DATA_W = 64,
    parameter int IW     = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [IW-1:0]     st_s_lo,
    input  logic [IW-1:0]     st_c_lo,
    input  logic [IW-1:0]     st_s_hi,
    input  logic [IW-1:0]     st_c_hi,
    input  logic              st_dot,
    input  logic              st_cin,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res
);
    localparam int TOP = 2 * LANE_W - 1;

    logic [IW-1:0]     m_s, m_c, f_s, f_c;
    logic [IW-1:0]     total;
    logic [DATA_W-1:0] res_d;

    dp4_csa #(.W(IW)) u_csa_a (.x(st_s_lo), .y(st_c_lo), .z(st_s_hi), .s(m_s), .c(m_c));
    dp4_csa #(.W(IW)) u_csa_b (.x(m_s),     .y(m_c),     .z(st_c_hi), .s(f_s), .c(f_c));

    always_comb begin
        total = f_s + f_c + IW'(st_cin);
        if (st_dot) begin
            res_d = {{(DATA_W - LANE_W){1'b0}}, total[TOP:LANE_W]};
        end else begin
            res_d = total[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= st_valid;
            if (st_valid) begin
                out_res <= res_d;
            end
        end
    end

    // R1: the merge keeps the sum of both carry-save pairs
    p_merge_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (IW'(f_s + f_c) == IW'(st_s_lo + st_c_lo + st_s_hi + st_c_hi)));

    // R7: second stage forwards valid by exactly one edge
    p_out_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> out_valid);
    p_out_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !out_valid);

    // R8: no new result means the output holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> $stable(out_res));
endmodule

// File: rtl/dp4_unit.sv
// Two-stage four-way dot-product / pair-sum unit.
module dp4_unit #(
    parameter int LANE_W = 16,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_signed,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_acc,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res
);
    localparam int IW = DATA_W + 4;

    logic          st_valid;
    logic [IW-1:0] st_s_lo, st_c_lo, st_s_hi, st_c_hi;
    logic          st_dot, st_cin;

    dp4_stage1 #(.LANE_W(LANE_W), .DATA_W(DATA_W), .IW(IW)) u_stage1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_signed (in_signed),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_acc    (in_acc),
        .st_valid  (st_valid),
        .st_s_lo   (st_s_lo),
        .st_c_lo   (st_c_lo),
        .st_s_hi   (st_s_hi),
        .st_c_hi   (st_c_hi),
        .st_dot    (st_dot),
        .st_cin    (st_cin)
    );

    dp4_stage2 #(.LANE_W(LANE_W), .DATA_W(DATA_W), .IW(IW)) u_stage2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_s_lo   (st_s_lo),
        .st_c_lo   (st_c_lo),
        .st_s_hi   (st_s_hi),
        .st_c_hi   (st_c_hi),
        .st_dot    (st_dot),
        .st_cin    (st_cin),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    // R7: first stage captures exactly the issued operations
    p_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> st_valid);
    p_issue_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !st_valid);
endmodule

// File: tb/dp4_unit_tb_top.sv
module dp4_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic        in_signed = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [63:0] in_acc = '0;
    logic        out_valid;
    logic [63:0] out_res;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [63:0] last_res = '0;

    typedef struct {
        logic [63:0] res;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dp4_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_signed(in_signed), .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
        .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [127:0] ext(input logic [63:0] x, input int w, input logic s);
        logic [127:0] v;
        v = '0;
        for (int i = 0; i < w; i++) v[i] = x[i];
        if (s && x[w-1]) v = v | ({128{1'b1}} << w);
        return v;
    endfunction

    function automatic logic [63:0] model(input logic [1:0] op, input logic s,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] acc);
        logic [127:0] t;
        t = '0;
        if (op == 2'd0) begin
            for (int i = 0; i < 4; i++)
                t = t + ext(64'(a[16*i +: 16]), 16, s) * ext(64'(b[16*i +: 16]), 16, s);
            t = t + 128'd32768;
            return {48'd0, t[31:16]};
        end
        for (int j = 0; j < 2; j++)
            t = t + ext(64'(a[32*j +: 32]), 32, s) * ext(64'(b[32*j +: 32]), 32, s);
        if (op == 2'd2) t = t + ext(acc, 64, s);
        if (op == 2'd3) t = t - ext(acc, 64, s);
        return t[63:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] op, input logic s,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] acc);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_op     = op;
        in_signed = s;
        in_a      = a;
        in_b      = b;
        in_acc    = acc;
        e.res = model(op, s, a, b, acc);
        e.due = cyc + 2;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = 2'($urandom);
            in_a     = {$urandom, $urandom};
            in_b     = {$urandom, $urandom};
            in_acc   = {$urandom, $urandom};
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected result", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, out_res, e.res);
                    check({e.tag, " R7 due cycle"}, 64'(cyc), 64'(e.due));
                    last_res = out_res;
                end
            end else begin
                check("R8 hold while idle", out_res, last_res);
                if (sb.size() != 0 && sb[0].due <= cyc)
                    check("R7 missing result", 64'(cyc), 64'(sb[0].due + 1));
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        in_a = 64'hFFFF_FFFF_FFFF_FFFF;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset valid", 64'(out_valid), 64'd0);
        check("R9 reset result", out_res, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R1 four-product, unsigned patterns
        drive("R1 dot unsigned small", 2'd0, 1'b0, 64'h0004_0003_0002_0001, 64'h8000_7000_6000_5000, 64'd0);
        drive("R1 dot unsigned mix", 2'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'd0);
        drive("R1 dot unsigned max", 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        // R10 single rounding: each pair alone is exactly 0x8000
        drive("R10 single rounding", 2'd0, 1'b0, 64'h0000_0001_0000_0001, 64'h0000_8000_0000_8000, 64'd0);
        // R2 signed vs unsigned
        drive("R2 dot signed neg", 2'd0, 1'b1, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0002, 64'd0);
        drive("R2 dot unsigned same", 2'd0, 1'b0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0002, 64'd0);
        drive("R2 dot signed all max", 2'd0, 1'b1, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'd0);
        drive("R2 dot signed all min", 2'd0, 1'b1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'd0);
        drive("R2 dot signed max*min", 2'd0, 1'b1, 64'h7FFF_8000_7FFF_8000, 64'h8000_8000_8000_7FFF, 64'd0);
        idle(3);

        // R3 pair sum
        drive("R3 pair unsigned", 2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        drive("R3 pair signed", 2'd1, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_8000_0000, 64'd0);
        // R4 / R5 accumulate and deduct
        drive("R4 pair add unsigned", 2'd2, 1'b0, 64'h0000_1234_0000_5678, 64'h0000_0010_0000_0020, 64'hFFFF_FFFF_FFFF_FFF0);
        drive("R4 pair add signed", 2'd2, 1'b1, 64'hFFFF_FFFF_0000_0003, 64'h0000_0005_0000_0007, 64'h8000_0000_0000_0000);
        drive("R5 pair sub unsigned", 2'd3, 1'b0, 64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005, 64'd100);
        drive("R5 pair sub signed", 2'd3, 1'b1, 64'h8000_0000_8000_0000, 64'h7FFF_FFFF_7FFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
        // R6 accumulator ignored in modes 0 and 1
        drive("R6 acc ignored dot", 2'd0, 1'b1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'hDEAD_BEEF_CAFE_F00D);
        drive("R6 acc ignored pair", 2'd1, 1'b0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 64'hDEAD_BEEF_CAFE_F00D);
        idle(4);

        // R7 back-to-back random burst, then R8 idle with junk inputs
        for (int k = 0; k < 60; k++) begin
            drive("R7 burst", 2'($urandom), 1'($urandom), {$urandom, $urandom},
                  {$urandom, $urandom}, {$urandom, $urandom});
            if (k % 13 == 12) idle(2);
        end
        idle(6);

        while (sb.size() != 0) @(negedge clk);
        idle(2);
        finish_run();
    end
endmodule